// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block sends one character at a time on a single serial output line. A frame starts with a low start slot. It then sends five to eight data bits, least significant bit first, and an optional parity slot. It ends with high stop time of one, one and a half or two bit lengths. A caller offers a byte on a valid/ready handshake. An external divider supplies a tick pulse at sixteen times the bit rate, and every slot is timed by counting those ticks. The line-control fields are sampled at the moment a byte is accepted, so the shape of each frame is fixed for its whole length.

The core is a five-state machine. `ST_IDLE` holds the line high and raises `in_ready`. On acceptance (transition *accept*) it moves to `ST_START`. After two half-bit periods (*start_done*) it moves to `ST_DATA`. The last data bit leaves either to `ST_PAR` when parity is enabled (*data_to_par*) or straight to `ST_STOP` (*data_to_stop*). The parity slot always ends in `ST_STOP` (*par_done*). The stop slot returns to `ST_IDLE` after its count of half-bit periods (*stop_done*). Every slot is timed in half-bit units. A full slot is two halves, and the stop slot is two, three or four halves. A live break input forces the line low at any time while the frame timing runs on underneath.

Top module: `sertx_top`

## Requirements
- R1: Each frame starts with a start slot driven low for 16 ticks and ends with stop time driven high.
- R2: The length code `ctl_len` selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Each data bit lasts 16 ticks and is sent least significant bit first. Byte bits above the selected length have no effect on the line.
- R3: With `ctl_stop2` = 0 the stop time is one bit (16 ticks) at every data length.
- R4: With `ctl_stop2` = 1 the stop time is 24 ticks for length code 00 and 32 ticks for the other codes.
- R5: With `ctl_par_en` = 1, one parity slot of 16 ticks follows the last data bit and comes before the stop time. With it at 0, the stop time follows the last data bit directly.
- R6: With `ctl_par_even` = 1 the parity bit makes the number of ones across the sent data bits and the parity bit even. With it at 0 that number is odd.
- R7: Frame timing moves on only on clock edges where `tick` is 1. While `tick` stays 0, the line and the slot hold.
- R8: `in_ready` is 1 only while idle, and a byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `busy` is 1 from the cycle after acceptance until the edge that ends the last stop half-bit, and `in_ready` is 0 for that whole time.
- R9: The control fields are sampled at acceptance. Changing them during a frame has no effect on that frame's bits or length.
- R10: While `ctl_break` is 1, `txd` is 0 whatever the state. The frame timing goes on, and the idle-high line returns once the input clears.
- R11: After reset the block is idle with `txd` = 1, `busy` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter can take a character |
| ctl_len | input | 2 | Data length code (00=5 ... 11=8) |
| ctl_stop2 | input | 1 | Long stop time select |
| ctl_par_en | input | 1 | Parity slot enable |
| ctl_par_even | input | 1 | Even (1) or odd (0) parity |
| ctl_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The properties assume that `tick` is a clean synchronous level sampled at the clock edge and that the controls change only between clock edges. They also assume that a character offered with `in_valid` stays offered until the handshake completes. The bench changes all inputs on the falling edge. It holds `in_valid` for exactly the accepting edge, and it moves `ctl_break` and the length fields only at chosen points of a frame. Most frames run with `tick` held high so that slot borders fall on known cycles. One frame stalls the tick on purpose to show that timing holds while it is low.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       stop2;
        logic       par_en;
        logic       par_even;
    } line_cfg_t;

endpackage

// File: rtl/sertx_halfbit.sv
module sertx_halfbit #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic half_done
);
    localparam int HALF = TICKS_PER_BIT / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end

    assign half_done = tick && (cnt == LAST) && !clr;

    // R7: no tick, no progress
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len,
    input  logic              even,
    output logic              par_bit
);
    localparam int MIN_BITS = DATA_W - 3;

    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] && (i < MIN_BITS + int'(len));
    end

    assign par_bit = even ? (^masked) : ~(^masked);

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_done,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  line_cfg_t         cfg_in,
    input  logic              par_in,
    output logic              accept,
    output logic              line,
    output logic              busy,
    output logic              ready
);
    localparam int MIN_BITS = DATA_W - 3;
    localparam int IW       = $clog2(DATA_W);

    tx_state_t         state, state_n;
    line_cfg_t         cfg;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [IW-1:0]     bit_idx;
    logic [2:0]        halves;
    logic              slot_end;
    logic [IW-1:0]     last_idx;
    logic [2:0]        stop_load;

    assign accept    = (state == ST_IDLE) && in_valid;
    assign slot_end  = half_done && (halves == 3'd0);
    assign last_idx  = IW'(MIN_BITS - 1 + int'(cfg.len));
    assign stop_load = !cfg.stop2 ? 3'd1 : ((cfg.len == 2'd0) ? 3'd2 : 3'd3);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (accept) state_n = ST_START;
            ST_START: if (slot_end) state_n = ST_DATA;
            ST_DATA:  if (slot_end && bit_idx == last_idx)
                          state_n = cfg.par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (slot_end) state_n = ST_STOP;
            ST_STOP:  if (slot_end) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            bit_idx <= '0;
            halves  <= 3'd0;
        end else if (accept) begin
            cfg     <= cfg_in;
            shreg   <= in_data;
            par_q   <= par_in;
            bit_idx <= '0;
            halves  <= 3'd1;
        end else if (half_done) begin
            if (halves != 3'd0) begin
                halves <= halves - 3'd1;
            end else begin
                if (state == ST_DATA) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + IW'(1);
                end
                if (state_n == ST_STOP)
                    halves <= stop_load;
                else
                    halves <= 3'd1;
            end
        end
    end

    always_comb begin
        line  = 1'b1;
        busy  = 1'b1;
        ready = 1'b0;
        unique case (state)
            ST_IDLE:  begin line = 1'b1; busy = 1'b0; ready = 1'b1; end
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            ST_STOP:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end

    // R5: the parity slot only appears in frames that asked for it
    a_r5_par_slot_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR) |-> cfg.par_en);

    // R9: captured format is frozen while a frame runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        ctl_len,
    input  logic              ctl_stop2,
    input  logic              ctl_par_en,
    input  logic              ctl_par_even,
    input  logic              ctl_break,
    output logic              txd,
    output logic              busy
);
    line_cfg_t cfg_in;
    logic      par_in;
    logic      accept;
    logic      half_done;
    logic      line;

    assign cfg_in = '{len: ctl_len, stop2: ctl_stop2,
                      par_en: ctl_par_en, par_even: ctl_par_even};

    sertx_parity #(.DATA_W(DATA_W)) u_par (
        .data    (in_data),
        .len     (ctl_len),
        .even    (ctl_par_even),
        .par_bit (par_in)
    );

    sertx_halfbit #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .tick      (tick),
        .half_done (half_done)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_done (half_done),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_in    (cfg_in),
        .par_in    (par_in),
        .accept    (accept),
        .line      (line),
        .busy      (busy),
        .ready     (in_ready)
    );

    assign txd = line && !ctl_break;

    // R1: a new frame opens with a low line
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R3: the last cycle of a frame is stop time, high unless broken
    a_r3_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(txd) || $past(ctl_break)));

    // R8: an accepted byte makes the block busy and not ready
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready));

    // R10: break wins over everything
    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_break |-> !txd);

    // R11: idle without break means a high line
    a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctl_break) |-> txd);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {data[12:5], len[4:3], stop2[2], par_en[1], par_even[0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {8'h55, 2'd3, 1'b0, 1'b0, 1'b0},
        {8'hA3, 2'd3, 1'b1, 1'b1, 1'b1},
        {8'hF5, 2'd0, 1'b1, 1'b1, 1'b0},
        {8'h3C, 2'd1, 1'b1, 1'b1, 1'b0},
        {8'h7F, 2'd2, 1'b0, 1'b1, 1'b1},
        {8'h00, 2'd0, 1'b0, 1'b1, 1'b0},
        {8'hFF, 2'd3, 1'b1, 1'b0, 1'b0},
        {8'h96, 2'd2, 1'b1, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] ctl_len = '0;
    logic       ctl_stop2 = 1'b0;
    logic       ctl_par_en = 1'b0;
    logic       ctl_par_even = 1'b0;
    logic       ctl_break = 1'b0;
    logic       txd;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .ctl_len(ctl_len),
        .ctl_stop2(ctl_stop2), .ctl_par_en(ctl_par_en),
        .ctl_par_even(ctl_par_even), .ctl_break(ctl_break),
        .txd(txd), .busy(busy)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] l,
                                    input logic ev);
        logic x = 1'b0;
        for (int i = 0; i < 5 + int'(l); i++) x ^= d[i];
        return ev ? x : ~x;
    endfunction

    function automatic logic exp_line(input int jj, input logic [7:0] d,
                                      input logic [1:0] l, input logic pe,
                                      input logic pv);
        int h = jj / 8;
        int n = 5 + int'(l);
        if (h < 2) return 1'b0;
        h -= 2;
        if (h < 2 * n) return d[h/2];
        h -= 2 * n;
        if (pe && h < 2) return par_of(d, l, pv);
        return 1'b1;
    endfunction

    function automatic string tag_of(input int jj, input logic [1:0] l,
                                     input logic pe);
        int h = jj / 8;
        int n = 5 + int'(l);
        if (h < 2) return "R1 start";
        if (h < 2 + 2 * n) return "R2 data";
        if (pe && h < 4 + 2 * n) return "R5 R6 parity";
        return "R3 R4 stop";
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] l,
                        input logic s, input logic pe, input logic pv,
                        input int stall, input bit chg, input bit brk);
        int n = 5 + int'(l);
        int t = 2 * (1 + n + int'(pe)) + (s ? ((l == 2'd0) ? 3 : 4) : 2);
        int last = 8 * t + stall;
        @(negedge clk);
        in_data = d; in_valid = 1'b1;
        ctl_len = l; ctl_stop2 = s; ctl_par_en = pe; ctl_par_even = pv;
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data = ~d;
        for (int j = 0; j <= last + 2; j++) begin
            int jj = j - stall;
            bit in_brk = brk && j > 20 && j <= 60;
            if (j >= 1 && j <= stall) begin
                chk("R7 stalled start line", txd, 1'b0);
                chk("R7 stalled busy", busy, 1'b1);
            end
            if (j == 5) chk("R8 ready low in frame", in_ready, 1'b0);
            if (in_brk && j == 24) chk("R10 break forces low", txd, 1'b0);
            if (jj >= 0 && jj < 8 * t && !in_brk &&
                ((jj % 16 == 8) || jj == 8 * t - 4))
                chk(tag_of(jj, l, pe), txd, exp_line(jj, d, l, pe, pv));
            if (jj == 8 * t - 1) chk("R3 R4 R8 busy at last cycle", busy, 1'b1);
            if (jj == 8 * t) begin
                chk("R3 R4 R8 busy clears", busy, 1'b0);
                chk("R8 ready returns", in_ready, 1'b1);
                chk("R1 idle high after frame", txd, 1'b1);
            end
            tick = (j >= stall) ? 1'b1 : 1'b0;
            if (chg && j == 40) begin
                ctl_len = ~l; ctl_stop2 = ~s; ctl_par_en = ~pe; ctl_par_even = ~pv;
            end
            if (brk && j == 20) ctl_break = 1'b1;
            if (brk && j == 60) ctl_break = 1'b0;
            @(negedge clk);
        end
        tick = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset txd", txd, 1'b1);
        chk("R11 reset busy", busy, 1'b0);
        chk("R11 reset ready", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle txd", txd, 1'b1);

        for (int v = 0; v < NVEC; v++)
            send(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], 0, 0, 0);

        // R7: tick held low for 30 cycles after acceptance
        send(8'h5A, 2'd3, 1'b0, 1'b1, 1'b0, 30, 0, 0);
        // R9: controls flipped mid-frame
        send(8'h81, 2'd3, 1'b0, 1'b1, 1'b1, 0, 1, 0);
        // R10: break during a frame, timing continues
        send(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 0, 0, 1);

        // R10: break while idle, then release
        @(negedge clk);
        ctl_break = 1'b1;
        @(negedge clk);
        chk("R10 idle break low", txd, 1'b0);
        chk("R10 break leaves block idle", busy, 1'b0);
        ctl_break = 1'b0;
        @(negedge clk);
        chk("R10 idle high resumes", txd, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule